// File: doc/BRIEF.md
# Serial Receive Character Queue with Threshold and Idle Timeout

This block buffers characters that a serial receiver has assembled, before a host reads them. Each stored entry holds one 8-bit character and three status bits for that character: parity error, framing error and line break. The bit layout of an entry, from most to least significant, is break, framing error, parity error, then the character. A parameter sets the depth to either 16 or 64 entries.

The block has two request outputs. The fill-threshold request is high while the number of stored characters is at or above a threshold, which a 2-bit code selects. The idle-timeout request reports characters that are left in the queue while the line is quiet. It can fire even when the fill level is below the threshold, so a short message does not stay unread.

An idle timer state machine drives the timeout. It has three states. `T_EMPTY` means the queue holds nothing. `T_COUNT` means characters are stored and the timer is counting idle cycles. `T_FIRED` means the idle limit has been reached. The transitions are:
- Any state moves to `T_EMPTY` when the queue will be empty after this cycle.
- Any state moves to `T_COUNT`, with the count reset, on an accepted write or on a host read while the queue stays non-empty.
- `T_COUNT` moves to `T_FIRED` when the idle count reaches four character times.
- `T_FIRED` holds until the next activity.

Top module: `rx_char_fifo`

## Requirements
- R1: After reset the fill level is 0, both requests and the overrun flag are low, and the read outputs are all zero.
- R2: Characters and their three status bits leave in write order. The entry appears on the read outputs in the cycle after the read strobe. The entry layout is {break, framing, parity, char[7:0]}.
- R3: The fill level goes up by one for each accepted write and down by one for each read of a non-empty queue, in the cycle after the strobe.
- R4: A write to a full queue with no read in the same cycle discards the character and sets a sticky overrun flag. Pulsing the overrun read strobe clears the flag.
- R5: A read of an empty queue leaves the read outputs and the fill level unchanged.
- R6: With depth 16, threshold codes 0, 1, 2 and 3 select fill thresholds of 1, 4, 8 and 14.
- R7: With depth 64, threshold codes 0, 1, 2 and 3 select fill thresholds of 8, 16, 56 and 60.
- R8: The fill-threshold request is high exactly while the fill level is at or above the selected threshold, so it drops as soon as the level falls below it.
- R9: With a non-empty queue and both enables high, the timeout request rises exactly 4*char_time clock edges after the last write or read.
- R10: Any accepted write or any host read restarts the idle count and lowers the timeout request. An empty queue never raises the timeout request.
- R11: The timeout request is low whenever either the queue enable or the receive-request enable is low, and the idle count keeps running while it is masked.
- R12: A write and a read in the same cycle on a full queue are both accepted: the level stays at full and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe from the receiver |
| wr_char | input | 8 | Assembled character |
| wr_par | input | 1 | Parity error for the character |
| wr_frm | input | 1 | Framing error for the character |
| wr_brk | input | 1 | Line break for the character |
| rd_en | input | 1 | Host read strobe |
| rd_char | output | 8 | Character from the last read |
| rd_par | output | 1 | Parity error from the last read |
| rd_frm | output | 1 | Framing error from the last read |
| rd_brk | output | 1 | Break from the last read |
| trig_code | input | 2 | Threshold select code |
| fifo_en | input | 1 | Queue enable (gates the timeout request) |
| rx_req_en | input | 1 | Receive request enable (gates the timeout request) |
| char_time | input | CT_W | Clock cycles per character time |
| ovr_rd | input | 1 | Overrun flag read strobe (clears the flag) |
| fill_level | output | $clog2(DEPTH+1) | Number of stored characters |
| data_avail_req | output | 1 | Fill level at or above the threshold |
| timeout_req | output | 1 | Idle timeout request |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The hardest case to reach from the ports is the exact edge on which the idle timer fires, together with each way that firing can be restarted or masked. The stimulus uses a small character time of 3 cycles and checks the timeout request on every cycle of the 12-cycle window. It then breaks the window with a write and then with a read, and lifts the enable mask only after the timer has already reached `T_FIRED` while masked. Both depths are swept through all four threshold codes from empty to full and back to empty, so every level is compared with the threshold.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [CHAR_W-1:0] ch;
    } rx_word_t;

    typedef enum logic [1:0] {
        T_EMPTY = 2'd0,
        T_COUNT = 2'd1,
        T_FIRED = 2'd2
    } tmr_state_e;

    // Threshold table: the large variant is used for depths of 64 and above.
    function automatic int trig_level(input int depth, input logic [1:0] code);
        if (depth >= 64) begin
            unique case (code)
                2'd0: return 8;
                2'd1: return 16;
                2'd2: return 56;
                default: return 60;
            endcase
        end else begin
            unique case (code)
                2'd0: return 1;
                2'd1: return 4;
                2'd2: return 8;
                default: return 14;
            endcase
        end
    endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  rx_word_t         wr_word,
    input  logic             rd_en,
    output rx_word_t         rd_word,
    output logic [CNT_W-1:0] level,
    output logic [CNT_W-1:0] level_nxt,
    output logic             wr_take,
    output logic             wr_drop,
    output logic             rd_take
);
    localparam int AW = $clog2(DEPTH);

    rx_word_t        mem [DEPTH];
    logic [AW-1:0]   wptr_q, rptr_q;
    logic            empty, full;

    assign empty     = (level == '0);
    assign full      = (level == CNT_W'(DEPTH));
    assign rd_take   = rd_en && !empty;
    assign wr_take   = wr_en && (!full || rd_take);
    assign wr_drop   = wr_en && !wr_take;
    assign level_nxt = level + CNT_W'(wr_take) - CNT_W'(rd_take);

    always_ff @(posedge clk) begin
        if (wr_take) mem[wptr_q] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            level   <= '0;
            rd_word <= '0;
        end else begin
            level <= level_nxt;
            if (wr_take) wptr_q <= wptr_q + AW'(1);
            if (rd_take) begin
                rd_word <= mem[rptr_q];
                rptr_q  <= rptr_q + AW'(1);
            end
        end
    end

    // R3
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH));

    // R5
    empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> $stable(rd_word));
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer
    import rxq_pkg::*;
#(
    parameter int CT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            activity,
    input  logic            hold_nz,
    input  logic [CT_W-1:0] char_time,
    output logic            fired
);
    localparam int TW = CT_W + 2;

    tmr_state_e    state_q, state_d;
    logic [TW-1:0] tmr_q, tmr_d, tmr_inc, limit;

    assign limit   = {char_time, 2'b00};
    assign tmr_inc = tmr_q + TW'(1);

    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        if (!hold_nz) begin
            state_d = T_EMPTY;
            tmr_d   = '0;
        end else if (activity) begin
            state_d = T_COUNT;
            tmr_d   = '0;
        end else begin
            unique case (state_q)
                T_EMPTY: begin
                    state_d = T_COUNT;
                    tmr_d   = '0;
                end
                T_COUNT: begin
                    if (tmr_inc >= limit) state_d = T_FIRED;
                    else tmr_d = tmr_inc;
                end
                T_FIRED: state_d = T_FIRED;
                default: state_d = T_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= T_EMPTY;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
        end
    end

    always_comb begin
        fired = (state_q == T_FIRED);
    end

    // R10
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> (state_q != T_FIRED));

    // R10
    empty_never_fired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_nz |=> (state_q == T_EMPTY));
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CT_W  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_char,
    input  logic             wr_par,
    input  logic             wr_frm,
    input  logic             wr_brk,
    input  logic             rd_en,
    output logic [7:0]       rd_char,
    output logic             rd_par,
    output logic             rd_frm,
    output logic             rd_brk,
    input  logic [1:0]       trig_code,
    input  logic             fifo_en,
    input  logic             rx_req_en,
    input  logic [CT_W-1:0]  char_time,
    input  logic             ovr_rd,
    output logic [CNT_W-1:0] fill_level,
    output logic             data_avail_req,
    output logic             timeout_req,
    output logic             overrun
);
    rx_word_t         wr_word, rd_word;
    logic [CNT_W-1:0] level_nxt, thr;
    logic             wr_take, wr_drop, rd_take, fired, ovr_q;

    assign wr_word = '{brk: wr_brk, frm: wr_frm, par: wr_par, ch: wr_char};

    rxq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
        .rd_en(rd_en), .rd_word(rd_word), .level(fill_level),
        .level_nxt(level_nxt), .wr_take(wr_take), .wr_drop(wr_drop),
        .rd_take(rd_take)
    );

    rxq_idle_timer #(.CT_W(CT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .activity(wr_take || rd_en),
        .hold_nz(level_nxt != '0), .char_time(char_time), .fired(fired)
    );

    assign thr            = CNT_W'(trig_level(DEPTH, trig_code));
    assign data_avail_req = (fill_level >= thr);
    assign timeout_req    = fired && fifo_en && rx_req_en;

    assign rd_char = rd_word.ch;
    assign rd_par  = rd_word.par;
    assign rd_frm  = rd_word.frm;
    assign rd_brk  = rd_word.brk;

    always_ff @(posedge clk) begin
        if (!rst_n)       ovr_q <= 1'b0;
        else if (wr_drop) ovr_q <= 1'b1;
        else if (ovr_rd)  ovr_q <= 1'b0;
    end
    assign overrun = ovr_q;

    // R4
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drop |=> overrun);

    // R12
    full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && fill_level == CNT_W'(DEPTH)) |=> (fill_level == CNT_W'(DEPTH)));

    // R10
    timeout_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_req |-> (fill_level != '0));

    // R3
    level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_en) |=> $stable(fill_level));
endmodule

// File: tb/tb_rx_char_fifo.sv
`timescale 1ns/1ps
module tb_rx_char_fifo;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0, sel64 = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, ovr_rd = 1'b0;
    logic [7:0] wr_char = '0;
    logic [2:0] wr_st = '0;
    logic [1:0] trig_code = '0;
    logic       fifo_en = 1'b1, rx_req_en = 1'b0;
    logic [7:0] char_time = 8'd255;

    logic [7:0] a_char, b_char;
    logic       a_par, a_frm, a_brk, b_par, b_frm, b_brk;
    logic [4:0] a_lvl;
    logic [6:0] b_lvl;
    logic       a_av, a_to, a_ov, b_av, b_to, b_ov;

    int errors = 0, checks = 0;

    rx_char_fifo #(.DEPTH(16), .CT_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && !sel64), .wr_char(wr_char),
        .wr_par(wr_st[0]), .wr_frm(wr_st[1]), .wr_brk(wr_st[2]),
        .rd_en(rd_en && !sel64), .rd_char(a_char), .rd_par(a_par),
        .rd_frm(a_frm), .rd_brk(a_brk), .trig_code(trig_code),
        .fifo_en(fifo_en), .rx_req_en(rx_req_en), .char_time(char_time),
        .ovr_rd(ovr_rd && !sel64), .fill_level(a_lvl),
        .data_avail_req(a_av), .timeout_req(a_to), .overrun(a_ov)
    );

    rx_char_fifo #(.DEPTH(64), .CT_W(8)) dut64 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && sel64), .wr_char(wr_char),
        .wr_par(wr_st[0]), .wr_frm(wr_st[1]), .wr_brk(wr_st[2]),
        .rd_en(rd_en && sel64), .rd_char(b_char), .rd_par(b_par),
        .rd_frm(b_frm), .rd_brk(b_brk), .trig_code(trig_code),
        .fifo_en(fifo_en), .rx_req_en(rx_req_en), .char_time(char_time),
        .ovr_rd(ovr_rd && sel64), .fill_level(b_lvl),
        .data_avail_req(b_av), .timeout_req(b_to), .overrun(b_ov)
    );

    function automatic int lvl();  return sel64 ? int'(b_lvl) : int'(a_lvl); endfunction
    function automatic int word(); return sel64 ? int'({b_brk, b_frm, b_par, b_char})
                                                : int'({a_brk, a_frm, a_par, a_char}); endfunction
    function automatic int av();   return sel64 ? int'(b_av) : int'(a_av); endfunction
    function automatic int ov();   return sel64 ? int'(b_ov) : int'(a_ov); endfunction
    function automatic int exp_word(int i);
        return ((i % 8) << 8) | ((i * 7 + 3) % 256);
    endfunction
    function automatic int exp_thr(int depth, int code);
        if (depth == 64) return (code == 0) ? 8 : (code == 1) ? 16 : (code == 2) ? 56 : 60;
        return (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
    endfunction

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push(input int i);
        wr_char = 8'((i * 7 + 3) % 256); wr_st = 3'(i % 8); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pop();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic sweep(input int depth, input int code);
        sel64 = (depth == 64); trig_code = 2'(code);
        do_reset();
        for (int i = 0; i < depth; i++) begin
            push(i);
            chk("R3 level up", lvl(), i + 1);
            chk(depth == 64 ? "R7 threshold" : "R6 threshold", av(), int'(i + 1 >= exp_thr(depth, code)));
        end
        push(depth);
        chk("R4 full write level", lvl(), depth);
        chk("R4 overrun set", ov(), 1);
        ovr_rd = 1'b1; @(negedge clk); ovr_rd = 1'b0;
        chk("R4 overrun cleared", ov(), 0);
        for (int i = 0; i < depth; i++) begin
            pop();
            chk("R2 order", word(), exp_word(i));
            chk("R3 level down", lvl(), depth - 1 - i);
            chk("R8 request drop", av(), int'(depth - 1 - i >= exp_thr(depth, code)));
        end
        pop();
        chk("R5 empty read word", word(), exp_word(depth - 1));
        chk("R5 empty read level", lvl(), 0);
    endtask

    initial begin
        #800000;
        errors++; checks++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        do_reset();
        // R1 reset state on both depths
        chk("R1 level16", int'(a_lvl), 0);
        chk("R1 level64", int'(b_lvl), 0);
        chk("R1 avail", int'(a_av | b_av), 0);
        chk("R1 timeout", int'(a_to | b_to), 0);
        chk("R1 overrun", int'(a_ov | b_ov), 0);
        chk("R1 read word", int'({a_brk, a_frm, a_par, a_char}), 0);

        for (int c = 0; c < 4; c++) sweep(16, c);
        for (int c = 0; c < 4; c++) sweep(64, c);

        // R12 write and read together on a full queue
        sel64 = 1'b0; trig_code = 2'd0;
        do_reset();
        for (int i = 0; i < 16; i++) push(i);
        wr_char = 8'((16 * 7 + 3) % 256); wr_st = 3'(16 % 8);
        wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R12 level stays full", lvl(), 16);
        chk("R12 no overrun", ov(), 0);
        chk("R12 read word", word(), exp_word(0));
        for (int i = 1; i <= 16; i++) begin
            pop();
            chk("R12 order after swap", word(), exp_word(i));
        end

        // R9 timeout window, char time 3 -> 12 edges
        char_time = 8'd3; rx_req_en = 1'b1; fifo_en = 1'b1;
        do_reset();
        push(0);
        for (int j = 1; j <= 12; j++) begin
            @(negedge clk);
            chk("R9 timeout edge", int'(a_to), int'(j == 12));
        end
        // R10 write restarts and clears
        push(1);
        chk("R10 write clears", int'(a_to), 0);
        for (int j = 1; j <= 6; j++) @(negedge clk);
        pop();
        chk("R10 read keeps low", int'(a_to), 0);
        chk("R10 level after read", lvl(), 1);
        for (int j = 1; j <= 12; j++) begin
            @(negedge clk);
            chk("R10 restart window", int'(a_to), int'(j == 12));
        end
        pop();
        chk("R10 read clears", int'(a_to), 0);
        for (int j = 1; j <= 20; j++) @(negedge clk);
        chk("R10 empty stays low", int'(a_to), 0);

        // R11 masking
        push(2);
        rx_req_en = 1'b0;
        for (int j = 1; j <= 15; j++) @(negedge clk);
        chk("R11 masked by rx enable", int'(a_to), 0);
        rx_req_en = 1'b1; #1;
        chk("R11 unmasked fires", int'(a_to), 1);
        fifo_en = 1'b0; #1;
        chk("R11 masked by fifo enable", int'(a_to), 0);
        fifo_en = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule